// File: doc/BRIEF.md
# Four-Bank Byte/Word FIFO

This block is the data store of a serial controller's transmit or receive path. It holds four byte-wide FIFO banks of equal depth side by side. A 32-bit port moves a whole word per access, with byte lane i of the word going to or coming from bank i. An 8-bit port moves a single byte per access and works on bank 0 only. Word traffic therefore sees four times the byte capacity of byte traffic.

Read data on both ports is show-ahead: the head entries are always visible, and a pop request advances past them. Every bank keeps its own pointers and count. Mixing the two widths can leave the banks unevenly filled, and the status flags report that condition.

Status is a six-bit sticky vector. A bit is set on the clock edge that follows the cycle in which its condition holds. It stays set until software writes a 1 to the matching clear bit. Any refused access sets the illegal-access bit, and that bit drives the interrupt output.

Top module: `qbf_fifo`

## Requirements
- R1: A word push writes byte lane i (bits 8i+7..8i) into bank i for i = 0..3. rd_word_data shows the four bank heads in the same lane order, and a word pop removes one entry from every bank, so words come out in the order they went in.
- R2: The byte port writes to and pops from bank 0 only. rd_byte_data always shows the head of bank 0.
- R3: Each bank holds 16 entries. The word port can therefore store 16 words (64 bytes), and the byte port can store 16 bytes.
- R4: A word push while any bank is full, or a byte push while bank 0 is full, is refused. The refused push sets the illegal-access bit and changes no stored data.
- R5: A word pop while any bank is empty, or a byte pop while bank 0 is empty, is refused. The refused pop sets the illegal-access bit and removes nothing.
- R6: If both push ports, or both pop ports, are requested in the same cycle, neither request of that pair is carried out and the illegal-access bit is set.
- R7: The status bit positions are: sts[0] empty (all banks hold 0 entries), sts[1] half (some bank holds 8 or more entries), sts[2] full (some bank holds 16 entries), sts[3] word available (every bank holds at least 1 entry), sts[4] byte available (bank 0 holds at least 1 entry), sts[5] illegal access. Each bit is set on the edge after its condition holds.
- R8: Status bits are sticky. Writing 1 to sts_clr[k] clears sts[k]. If the condition for bit k still holds at that edge, the set wins and the bit stays 1.
- R9: irq is high exactly while sts[5] is set.
- R10: After reset all banks are empty and sts equals 6'b000001.
- R11: A push and a pop on the word port in the same cycle both take effect. Each is checked against the fill levels from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_word_en | input | 1 | Push one 32-bit word across all banks |
| wr_word_data | input | 32 | Word to push, lane i to bank i |
| wr_byte_en | input | 1 | Push one byte into bank 0 |
| wr_byte_data | input | 8 | Byte to push |
| rd_word_en | input | 1 | Pop one word from all banks |
| rd_word_data | output | 32 | Heads of the four banks, lane i from bank i |
| rd_byte_en | input | 1 | Pop one byte from bank 0 |
| rd_byte_data | output | 8 | Head of bank 0 |
| sts_clr | input | 6 | Write-one-to-clear mask for the status bits |
| sts | output | 6 | Sticky status vector |
| irq | output | 1 | Illegal-access interrupt |

## Verification
A bank pointer that slips shows up on the next pop as a wrong or repeated lane in rd_word_data or rd_byte_data. Because each entry is checked against its push order, the bench sees this within one access. A count that drifts from the true fill level shows in sts two edges after the access that caused it. The drift appears as a missing or spurious full, half or available bit, or as an illegal-access bit that sets when it should not, or fails to set when it should. A wrong illegal-access decision also shows directly on irq one edge later.

// File: rtl/qbf_pkg.sv
`timescale 1ns/1ps
package qbf_pkg;
    localparam int unsigned STS_W = 6;

    typedef struct packed {
        logic illegal;
        logic byte_av;
        logic word_av;
        logic full;
        logic half;
        logic empty;
    } qbf_sts_t;
endpackage

// File: rtl/qbf_bank.sv
`timescale 1ns/1ps
module qbf_bank #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned BW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [BW-1:0] din,
    output logic [BW-1:0] dout,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][BW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> count != CW'(DEPTH)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0); // R5
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |=> count == $past(count) + 1'b1); // R3
endmodule

// File: rtl/qbf_status.sv
`timescale 1ns/1ps
module qbf_status
    import qbf_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned NBANK = 4,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NBANK-1:0][CW-1:0]  counts,
    input  logic                      illegal_req,
    input  qbf_sts_t                  clr,
    output qbf_sts_t                  sts
);
    qbf_sts_t lvl;
    qbf_sts_t sts_d, sts_q;

    always_comb begin
        lvl         = '0;
        lvl.empty   = 1'b1;
        lvl.word_av = 1'b1;
        for (int i = 0; i < NBANK; i++) begin
            if (counts[i] != '0)              lvl.empty   = 1'b0;
            if (counts[i] == '0)              lvl.word_av = 1'b0;
            if (counts[i] >= CW'(DEPTH / 2))  lvl.half    = 1'b1;
            if (counts[i] == CW'(DEPTH))      lvl.full    = 1'b1;
        end
        lvl.byte_av = (counts[0] != '0);
        lvl.illegal = illegal_req;
        sts_d = (sts_q & ~clr) | lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q       <= '0;
            sts_q.empty <= 1'b1;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts = sts_q;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q.full && !clr.full |=> sts_q.full); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr.word_av && counts[0] == '0 |=> !sts_q.word_av); // R8
endmodule

// File: rtl/qbf_fifo.sv
`timescale 1ns/1ps
module qbf_fifo
    import qbf_pkg::*;
#(
    parameter int unsigned NBANK = 4,
    parameter int unsigned BW    = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned WW   = NBANK * BW,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_word_en,
    input  logic [WW-1:0]    wr_word_data,
    input  logic             wr_byte_en,
    input  logic [BW-1:0]    wr_byte_data,
    input  logic             rd_word_en,
    output logic [WW-1:0]    rd_word_data,
    input  logic             rd_byte_en,
    output logic [BW-1:0]    rd_byte_data,
    input  logic [STS_W-1:0] sts_clr,
    output logic [STS_W-1:0] sts,
    output logic             irq
);
    logic [NBANK-1:0][CW-1:0] cnt_b;
    logic [NBANK-1:0][BW-1:0] dout_b;
    logic [NBANK-1:0][BW-1:0] din_b;
    logic [NBANK-1:0]         push_b, pop_b;
    logic any_full, any_empty, b0_full, b0_empty;
    logic push_clash, pop_clash;
    logic w_push_ok, b_push_ok, w_pop_ok, b_pop_ok;
    logic illegal_req;
    qbf_sts_t sts_s;

    always_comb begin
        any_full  = 1'b0;
        any_empty = 1'b0;
        for (int i = 0; i < NBANK; i++) begin
            if (cnt_b[i] == CW'(DEPTH)) any_full  = 1'b1;
            if (cnt_b[i] == '0)         any_empty = 1'b1;
        end
        b0_full  = (cnt_b[0] == CW'(DEPTH));
        b0_empty = (cnt_b[0] == '0);

        push_clash = wr_word_en & wr_byte_en;
        pop_clash  = rd_word_en & rd_byte_en;
        w_push_ok  = wr_word_en & ~wr_byte_en & ~any_full;
        b_push_ok  = wr_byte_en & ~wr_word_en & ~b0_full;
        w_pop_ok   = rd_word_en & ~rd_byte_en & ~any_empty;
        b_pop_ok   = rd_byte_en & ~rd_word_en & ~b0_empty;

        illegal_req = push_clash | pop_clash
                    | (wr_word_en & ~wr_byte_en & any_full)
                    | (wr_byte_en & ~wr_word_en & b0_full)
                    | (rd_word_en & ~rd_byte_en & any_empty)
                    | (rd_byte_en & ~rd_word_en & b0_empty);
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        if (g == 0) begin : g_lane0
            assign push_b[g] = w_push_ok | b_push_ok;
            assign pop_b[g]  = w_pop_ok  | b_pop_ok;
            assign din_b[g]  = w_push_ok ? wr_word_data[g*BW +: BW] : wr_byte_data;
        end else begin : g_lane
            assign push_b[g] = w_push_ok;
            assign pop_b[g]  = w_pop_ok;
            assign din_b[g]  = wr_word_data[g*BW +: BW];
        end

        qbf_bank #(.DEPTH(DEPTH), .BW(BW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_b[g]),
            .pop   (pop_b[g]),
            .din   (din_b[g]),
            .dout  (dout_b[g]),
            .count (cnt_b[g])
        );
    end

    qbf_status #(.DEPTH(DEPTH), .NBANK(NBANK)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .counts      (cnt_b),
        .illegal_req (illegal_req),
        .clr         (qbf_sts_t'(sts_clr)),
        .sts         (sts_s)
    );

    assign rd_word_data = dout_b;
    assign rd_byte_data = dout_b[0];
    assign sts          = sts_s;
    assign irq          = sts_s.illegal;

    AST_CLASH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word_en && wr_byte_en |-> push_b == '0); // R6
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_req |=> irq); // R9
    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word_en && !rd_byte_en && !any_empty |-> pop_b == '1); // R1
endmodule

// File: tb/sim_qbf_fifo.sv
`timescale 1ns/1ps
module sim_qbf_fifo;
    localparam logic [5:0] ALL = 6'h3F;
    localparam logic [5:0] NOILL = 6'h1F;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] data;
        logic [1:0]  chk;
        logic [31:0] exp_rd;
        logic [5:0]  exp_sts;
    } vec_t;

    // op: 0 idle, 1 push word, 2 push byte, 3 pop word, 4 pop byte,
    //     5 both pushes, 6 both pops, 7 push+pop word
    localparam vec_t VEC [11] = '{
        '{4'd1, 32'h44332211, 2'd0, 32'h0,        6'h18}, // R1
        '{4'd2, 32'h000000AA, 2'd0, 32'h0,        6'h18}, // R2
        '{4'd1, 32'h88776655, 2'd0, 32'h0,        6'h18}, // R1
        '{4'd2, 32'h000000BB, 2'd0, 32'h0,        6'h18}, // R2
        '{4'd3, 32'h0,        2'd1, 32'h44332211, 6'h18}, // R1
        '{4'd3, 32'h0,        2'd1, 32'h887766AA, 6'h10}, // R1 R7
        '{4'd3, 32'h0,        2'd0, 32'h0,        6'h30}, // R5
        '{4'd4, 32'h0,        2'd2, 32'h00000055, 6'h10}, // R2
        '{4'd4, 32'h0,        2'd2, 32'h000000BB, 6'h01}, // R2 R7
        '{4'd4, 32'h0,        2'd0, 32'h0,        6'h21}, // R5
        '{4'd5, 32'h12345678, 2'd0, 32'h0,        6'h21}  // R6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_word_en = 1'b0, wr_byte_en = 1'b0, rd_word_en = 1'b0, rd_byte_en = 1'b0;
    logic [31:0] wr_word_data = '0;
    logic [7:0]  wr_byte_data = '0;
    logic [5:0]  sts_clr = '0;
    logic [31:0] rd_word_data;
    logic [7:0]  rd_byte_data;
    logic [5:0]  sts;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qbf_fifo u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_word_en(wr_word_en), .wr_word_data(wr_word_data),
        .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
        .rd_word_en(rd_word_en), .rd_word_data(rd_word_data),
        .rd_byte_en(rd_byte_en), .rd_byte_data(rd_byte_data),
        .sts_clr(sts_clr), .sts(sts), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [3:0] op, input logic [31:0] d, input logic [5:0] clr);
        wr_word_en   = (op == 4'd1) || (op == 4'd5) || (op == 4'd7);
        wr_byte_en   = (op == 4'd2) || (op == 4'd5);
        rd_word_en   = (op == 4'd3) || (op == 4'd6) || (op == 4'd7);
        rd_byte_en   = (op == 4'd4) || (op == 4'd6);
        wr_word_data = d;
        wr_byte_data = d[7:0];
        sts_clr      = clr;
        @(negedge clk);
        wr_word_en = 1'b0; wr_byte_en = 1'b0; rd_word_en = 1'b0; rd_byte_en = 1'b0;
        sts_clr = '0;
    endtask

    // op with fresh status: clear all with the op, then clear all but illegal
    task automatic step(input logic [3:0] op, input logic [31:0] d);
        cyc(op, d, ALL);
        cyc(4'd0, 32'h0, NOILL);
    endtask

    function automatic logic [31:0] wd(input int i);
        return 32'hA0B0C0D0 + 32'h01010101 * i;
    endfunction

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset sts", {26'h0, sts}, 32'h01);
        chk("R9 reset irq", {31'h0, irq}, 32'h0);

        foreach (VEC[k]) begin
            if (VEC[k].chk == 2'd1) chk("R1 word head", rd_word_data, VEC[k].exp_rd);
            if (VEC[k].chk == 2'd2) chk("R2 byte head", {24'h0, rd_byte_data}, VEC[k].exp_rd);
            step(VEC[k].op, VEC[k].data);
            chk("R7 table sts", {26'h0, sts}, {26'h0, VEC[k].exp_sts});
        end
        chk("R9 irq with illegal", {31'h0, irq}, 32'h1);
        cyc(4'd0, 32'h0, 6'h20);
        @(negedge clk);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 re-reset sts", {26'h0, sts}, 32'h01);

        // half threshold and word capacity
        for (int i = 0; i < 7; i++) cyc(4'd1, wd(i), ALL);
        step(4'd0, 32'h0);
        chk("R7 seven not half", {26'h0, sts}, 32'h18);
        cyc(4'd1, wd(7), ALL);
        step(4'd0, 32'h0);
        chk("R7 eight half", {26'h0, sts}, 32'h1A);
        for (int i = 8; i < 16; i++) cyc(4'd1, wd(i), ALL);
        step(4'd0, 32'h0);
        chk("R3 sixteen words full", {26'h0, sts}, 32'h1E);
        step(4'd1, 32'hDEADBEEF);
        chk("R4 push on full sts", {26'h0, sts}, 32'h3E);
        chk("R9 irq on full push", {31'h0, irq}, 32'h1);
        chk("R4 head unchanged", rd_word_data, wd(0));
        cyc(4'd0, 32'h0, 6'h04);
        @(negedge clk);
        chk("R8 set wins while full", {31'h0, sts[2]}, 32'h1);
        chk("R1 pop 0", rd_word_data, wd(0));
        cyc(4'd3, 32'h0, 6'h00);
        @(negedge clk);
        chk("R8 full sticky", {31'h0, sts[2]}, 32'h1);
        cyc(4'd0, 32'h0, 6'h04);
        @(negedge clk);
        chk("R8 full cleared", {31'h0, sts[2]}, 32'h0);
        for (int i = 1; i < 16; i++) begin
            chk("R1 pop order", rd_word_data, wd(i));
            cyc(4'd3, 32'h0, 6'h00);
        end
        step(4'd0, 32'h0);
        chk("R3 drained", {26'h0, sts}, 32'h01);
        step(4'd3, 32'h0);
        chk("R5 pop on empty", {26'h0, sts}, 32'h21);

        // byte port capacity and bank 0 only
        for (int i = 0; i < 16; i++) cyc(4'd2, 32'h30 + i, ALL);
        step(4'd0, 32'h0);
        chk("R3 sixteen bytes full", {26'h0, sts}, 32'h16);
        step(4'd2, 32'hEE);
        chk("R4 byte push on full", {26'h0, sts}, 32'h36);
        chk("R4 byte head unchanged", {24'h0, rd_byte_data}, 32'h30);
        step(4'd3, 32'h0);
        chk("R5 word pop uneven", {26'h0, sts}, 32'h36);
        step(4'd1, 32'h0);
        chk("R4 word push b0 full", {26'h0, sts}, 32'h36);
        for (int i = 0; i < 16; i++) begin
            chk("R2 byte order", {24'h0, rd_byte_data}, 32'h30 + i);
            cyc(4'd4, 32'h0, 6'h00);
        end
        step(4'd0, 32'h0);
        chk("R2 byte drained", {26'h0, sts}, 32'h01);

        // both pops clash, simultaneous push and pop
        step(4'd1, 32'hCAFE0001);
        step(4'd6, 32'h0);
        chk("R6 pop clash sts", {26'h0, sts}, 32'h38);
        chk("R6 pop clash kept", rd_word_data, 32'hCAFE0001);
        step(4'd7, 32'hCAFE0002);
        chk("R11 push+pop sts", {26'h0, sts}, 32'h18);
        chk("R11 push+pop data", rd_word_data, 32'hCAFE0002);

        done = 1'b1;
        report();
    end
endmodule